// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a byte-wide flash memory with 128K byte addresses. It watches the external chip-enable, output-enable and write-enable strobes, which it samples on the system clock, and turns host write cycles into commands. Most commands are a pair of bus cycles: either two matching writes, or a write followed by reads. The block drives an abstract array backend through a request/acknowledge port with a busy input. The backend models the storage array, high-voltage behaviour and pulse timing.

On the read side the block selects what the data bus returns. This can be array data at the live address, array data at a latched verify address, one of two identifier codes, or a single completion flag on bit 7 during automatic erase. It also gates the per-bit drive enables of the data bus. While the programming supply is not applied, the block stays in plain array-read mode.

Top module: `flash_cmd_ctrl_top`

## Requirements
- R1: After reset with the programming supply applied, the block is in array-read mode. A read returns `arrayData` for the live address (`rdAddr` equals `addr`), and `opReq` is low.
- R2: After a write of 90h, reads return identifier codes. Address bit 0 low gives 07h and address bit 0 high gives 19h. A later write of 00h returns the block to array read.
- R3: Two consecutive writes of 20h issue an erase request, opCode 1. If the first write is 20h and the second write is any other value, no request is issued and the block drops to array-read mode.
- R4: Two consecutive writes of 30h issue an auto-erase request, opCode 2, and enter status mode.
- R5: Two consecutive writes of FFh issue a reset request, opCode 3. FFh followed by any other value issues nothing.
- R6: A write of 40h arms programming. The next write issues a program request, opCode 0. Its `opAddr` and `opData` are the address and data of that second write.
- R7: After a write of C0h, reads return `arrayData` at the last programmed address. After a write of A0h, reads return `arrayData` at the address of that A0h write. In both cases the live address input has no effect.
- R8: A write cycle is taken only while chip-enable is low. The address is taken at the write-enable falling edge and the data at the rising edge. A strobe with chip-enable high has no effect.
- R9: In status mode a read drives only bit 7 (`dataOe` = 80h). The value is 00h from the auto-erase issue until the backend is no longer busy, and 80h after that.
- R10: `dataOe` is nonzero only while chip-enable and output-enable are low and write-enable is high.
- R11: While `opBusy` is high or a request is waiting for its acknowledge, command writes are ignored. Status reads keep working.
- R12: `opReq`, once raised, stays high with a stable `opCode` until `opAck` is seen.
- R13: While `vppHigh` is low, the block is held in array-read mode and command writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | active-low asynchronous reset |
| vppHigh | input | 1 | programming supply applied |
| ceN | input | 1 | chip enable, active low |
| oeN | input | 1 | output enable, active low |
| weN | input | 1 | write enable, active low |
| addr | input | ADDR_W | byte address |
| dataIn | input | DATA_W | data bus input |
| dataOut | output | DATA_W | data bus output value |
| dataOe | output | DATA_W | per-bit data bus drive enable |
| rdAddr | output | ADDR_W | address presented to the backend for readback |
| arrayData | input | DATA_W | backend data at rdAddr |
| opReq | output | 1 | operation request |
| opCode | output | 2 | 0 program, 1 erase, 2 auto-erase, 3 reset |
| opAddr | output | ADDR_W | operation address |
| opData | output | DATA_W | operation data |
| opAck | input | 1 | backend accepts the request |
| opBusy | input | 1 | backend operation in progress |

## Verification
The assertions assume that the strobes and buses are synchronous to `clk` and that the backend raises `opBusy` no later than the cycle in which it raises `opAck`. They also assume the backend holds `opBusy` high for the whole automatic erase. The bench drives every strobe on the falling clock edge, with each write-enable low and high phase lasting one full cycle while chip-enable is low. Its backend model acknowledges one cycle after a request and raises busy in that same cycle, so every observed sequence stays inside these assumptions.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_W = 8;
  localparam logic [CMD_W-1:0] CMD_READ  = 8'h00;
  localparam logic [CMD_W-1:0] CMD_IDENT = 8'h90;
  localparam logic [CMD_W-1:0] CMD_ERASE = 8'h20;
  localparam logic [CMD_W-1:0] CMD_AUTO  = 8'h30;
  localparam logic [CMD_W-1:0] CMD_PROG  = 8'h40;
  localparam logic [CMD_W-1:0] CMD_PVER  = 8'hC0;
  localparam logic [CMD_W-1:0] CMD_EVER  = 8'hA0;
  localparam logic [CMD_W-1:0] CMD_RST   = 8'hFF;
  localparam logic [CMD_W-1:0] ID_MAKER  = 8'h07;
  localparam logic [CMD_W-1:0] ID_PART   = 8'h19;

  typedef enum logic [2:0] {M_READ, M_IDENT, M_PVER, M_EVER, M_STATUS} mode_t;
  typedef enum logic [2:0] {P_NONE, P_ERASE, P_AUTO, P_RST, P_PROG} pend_t;
  typedef enum logic [1:0] {OP_PROG, OP_ERASE, OP_AUTO, OP_RST} op_t;

  typedef struct packed {
    logic capAddr;
    logic capVAddr;
    logic loadOp;
  } dp_strobe_t;
endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vppHigh,
  input  logic              ceN,
  input  logic              weN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              opAck,
  input  logic              opBusy,
  output mode_t             mode,
  output dp_strobe_t        strobe,
  output logic              opReq,
  output op_t               opCode,
  output logic              statDone
);
  localparam int CW = (DATA_W < CMD_W) ? DATA_W : CMD_W;

  logic weQ, autoRun, issue, capV, blocked, accept;
  pend_t pend, nextPend;
  mode_t nextMode;
  op_t issueCode;
  logic [CW-1:0] cmd;

  wire wrFall = weQ && !weN && !ceN;
  wire wrRise = !weQ && weN && !ceN;

  assign cmd     = dataIn[CW-1:0];
  assign blocked = opBusy || opReq;
  assign accept  = wrRise && vppHigh && !blocked;

  always_comb begin
    nextMode  = mode;
    nextPend  = pend;
    issue     = 1'b0;
    issueCode = OP_PROG;
    capV      = 1'b0;
    if (!vppHigh) begin
      nextMode = M_READ;
      nextPend = P_NONE;
    end else if (accept) begin
      nextPend = P_NONE;
      case (pend)
        P_PROG: begin
          issue = 1'b1; issueCode = OP_PROG; capV = 1'b1; nextMode = M_READ;
        end
        P_ERASE: begin
          nextMode = M_READ;
          if (cmd == CMD_ERASE[CW-1:0]) begin issue = 1'b1; issueCode = OP_ERASE; end
        end
        P_AUTO: begin
          nextMode = M_READ;
          if (cmd == CMD_AUTO[CW-1:0]) begin
            issue = 1'b1; issueCode = OP_AUTO; nextMode = M_STATUS;
          end
        end
        P_RST: begin
          nextMode = M_READ;
          if (cmd == CMD_RST[CW-1:0]) begin issue = 1'b1; issueCode = OP_RST; end
        end
        default: begin
          case (cmd)
            CMD_IDENT[CW-1:0]: nextMode = M_IDENT;
            CMD_ERASE[CW-1:0]: nextPend = P_ERASE;
            CMD_AUTO[CW-1:0]:  nextPend = P_AUTO;
            CMD_RST[CW-1:0]:   nextPend = P_RST;
            CMD_PROG[CW-1:0]:  nextPend = P_PROG;
            CMD_PVER[CW-1:0]:  nextMode = M_PVER;
            CMD_EVER[CW-1:0]:  begin nextMode = M_EVER; capV = 1'b1; end
            default:           nextMode = M_READ;
          endcase
        end
      endcase
    end
  end

  assign strobe.capAddr  = wrFall;
  assign strobe.capVAddr = capV;
  assign strobe.loadOp   = issue;
  assign statDone        = !autoRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ     <= 1'b1;
      mode    <= M_READ;
      pend    <= P_NONE;
      opReq   <= 1'b0;
      opCode  <= OP_PROG;
      autoRun <= 1'b0;
    end else begin
      weQ  <= weN;
      mode <= nextMode;
      pend <= nextPend;
      if (issue) begin
        opReq  <= 1'b1;
        opCode <= issueCode;
      end else if (opAck) begin
        opReq <= 1'b0;
      end
      if (issue && issueCode == OP_AUTO) autoRun <= 1'b1;
      else if (autoRun && !opReq && !opBusy) autoRun <= 1'b0;
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opReq && !opAck) |=> (opReq && $stable(opCode)));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blocked && vppHigh) |=> ($stable(mode) && $stable(pend)));
  // R13
  vpp_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vppHigh |=> (mode == M_READ && pend == P_NONE));
  // R4
  auto_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(opReq) && opCode == OP_AUTO |-> (mode == M_STATUS && !statDone));
endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  mode_t             mode,
  input  logic              statDone,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData
);
  localparam logic [DATA_W-1:0] TOP_BIT = DATA_W'(1) << (DATA_W-1);

  logic [ADDR_W-1:0] wrAddr, vAddr;
  logic outEn;

  assign outEn  = !ceN && !oeN && weN;
  assign rdAddr = (mode == M_PVER || mode == M_EVER) ? vAddr : addr;

  always_comb begin
    case (mode)
      M_IDENT:  dataOut = addr[0] ? DATA_W'(ID_PART) : DATA_W'(ID_MAKER);
      M_STATUS: dataOut = statDone ? TOP_BIT : '0;
      default:  dataOut = arrayData;
    endcase
    if (!outEn) dataOe = '0;
    else if (mode == M_STATUS) dataOe = TOP_BIT;
    else dataOe = '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr <= '0;
      vAddr  <= '0;
      opAddr <= '0;
      opData <= '0;
    end else begin
      if (strobe.capAddr)  wrAddr <= addr;
      if (strobe.capVAddr) vAddr  <= wrAddr;
      if (strobe.loadOp) begin
        opAddr <= wrAddr;
        opData <= dataIn;
      end
    end
  end

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceN || oeN || !weN) |-> (dataOe == '0));
  // R2
  ident_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_IDENT) |-> (dataOut == (addr[0] ? DATA_W'(ID_PART) : DATA_W'(ID_MAKER))));
  // R9
  status_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == M_STATUS && outEn) |-> (dataOe == TOP_BIT && (dataOut & ~TOP_BIT) == '0));
endmodule

// File: rtl/flash_cmd_ctrl_top.sv
module flash_cmd_ctrl_top
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vppHigh,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOe,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] arrayData,
  output logic              opReq,
  output logic [1:0]        opCode,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  input  logic              opAck,
  input  logic              opBusy
);
  mode_t      mode;
  dp_strobe_t strobe;
  op_t        opKind;
  logic       statDone;

  assign opCode = opKind;

  flash_cmd_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .vppHigh(vppHigh), .ceN(ceN), .weN(weN),
    .dataIn(dataIn), .opAck(opAck), .opBusy(opBusy), .mode(mode),
    .strobe(strobe), .opReq(opReq), .opCode(opKind), .statDone(statDone)
  );

  flash_cmd_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode), .statDone(statDone),
    .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr), .dataIn(dataIn),
    .arrayData(arrayData), .dataOut(dataOut), .dataOe(dataOe),
    .rdAddr(rdAddr), .opAddr(opAddr), .opData(opData)
  );
endmodule

// File: tb/test_flash_cmd_ctrl_top.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl_top;
  logic clk = 1'b0, rstN = 1'b0, vppHigh = 1'b1;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut, dataOe, arrayData;
  logic [16:0] rdAddr, opAddr;
  logic [7:0] opData;
  logic opReq, opAck = 1'b0, opBusy = 1'b0;
  logic [1:0] opCode;

  int total = 0, bad = 0, opCount = 0, busyCnt = 0;
  logic [1:0] lastCode;
  logic [16:0] lastAddr;
  logic [7:0] lastData;
  logic [7:0] rv, ro;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign arrayData = rdAddr[7:0] ^ 8'h5A;

  flash_cmd_ctrl_top i_flash_cmd_ctrl_top (
    .clk(clk), .rstN(rstN), .vppHigh(vppHigh), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .rdAddr(rdAddr), .arrayData(arrayData), .opReq(opReq), .opCode(opCode),
    .opAddr(opAddr), .opData(opData), .opAck(opAck), .opBusy(opBusy)
  );

  // backend model: ack one cycle after request, busy raised with ack for auto-erase
  initial forever begin
    @(negedge clk);
    if (busyCnt > 0) begin
      busyCnt--;
      if (busyCnt == 0) opBusy = 1'b0;
    end
    if (opReq && !opAck) begin
      opAck = 1'b1;
      opCount++;
      lastCode = opCode; lastAddr = opAddr; lastData = opData;
      if (opCode == 2'd2) begin opBusy = 1'b1; busyCnt = 30; end
    end else opAck = 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wrx(input logic [16:0] aF, input logic [16:0] aR,
                     input logic [7:0] dF, input logic [7:0] dR, input bit ce);
    @(negedge clk);
    ceN = !ce; oeN = 1'b1; addr = aF; dataIn = dF; weN = 1'b0;
    @(negedge clk);
    addr = aR; dataIn = dR; weN = 1'b1;
    @(negedge clk);
    ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    wrx(a, a, d, d, 1'b1);
  endtask

  task automatic rd(input logic [16:0] a);
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b0; weN = 1'b1; addr = a;
    #1;
    rv = dataOut; ro = dataOe;
    oeN = 1'b1; ceN = 1'b1;
  endtask

  task automatic t_reset();
    rd(17'h00123);
    chk("R1 read data", rv, 8'h23 ^ 8'h5A);
    chk("R1 read oe", ro, 8'hFF);
    chk("R1 rdAddr", rdAddr, 17'h00123);
    chk("R1 no req", opReq, 1'b0);
    @(negedge clk); ceN = 1'b0; oeN = 1'b1; #1;
    chk("R10 oe high", dataOe, 8'h00);
    oeN = 1'b0; weN = 1'b0; #1;
    chk("R10 we low", dataOe, 8'h00);
    weN = 1'b1; ceN = 1'b1; oeN = 1'b1; #1;
    chk("R10 ce high", dataOe, 8'h00);
  endtask

  task automatic t_ident();
    wr(17'h0, 8'h90);
    rd(17'h00000); chk("R2 maker", rv, 8'h07);
    rd(17'h00001); chk("R2 part", rv, 8'h19);
    rd(17'h1FFFE); chk("R2 maker hi addr", rv, 8'h07);
    wr(17'h0, 8'h00);
    rd(17'h00001); chk("R2 back to array", rv, 8'h01 ^ 8'h5A);
  endtask

  task automatic t_erase();
    int c0 = opCount;
    wr(17'h0, 8'h20); wr(17'h0, 8'h20);
    chk("R3 erase issued", opCount, c0 + 1);
    chk("R3 erase code", lastCode, 2'd1);
    chk("R12 req dropped", opReq, 1'b0);
    wr(17'h0, 8'h90);
    wr(17'h0, 8'h20); wr(17'h0, 8'h55);
    chk("R3 mismatch none", opCount, c0 + 1);
    rd(17'h00001); chk("R3 mismatch read mode", rv, 8'h01 ^ 8'h5A);
  endtask

  task automatic t_rst();
    int c0 = opCount;
    wr(17'h0, 8'hFF); wr(17'h0, 8'hFF);
    chk("R5 reset issued", opCount, c0 + 1);
    chk("R5 reset code", lastCode, 2'd3);
    wr(17'h0, 8'hFF); wr(17'h0, 8'h00);
    chk("R5 mismatch none", opCount, c0 + 1);
  endtask

  task automatic t_prog();
    int c0 = opCount;
    wr(17'h0, 8'h40); wr(17'h1ABCD, 8'h3C);
    chk("R6 prog issued", opCount, c0 + 1);
    chk("R6 prog code", lastCode, 2'd0);
    chk("R6 prog addr", lastAddr, 17'h1ABCD);
    chk("R6 prog data", lastData, 8'h3C);
    wr(17'h0, 8'hC0);
    rd(17'h00011); chk("R7 prog verify", rv, 8'hCD ^ 8'h5A);
    wr(17'h0F0F0, 8'hA0);
    rd(17'h00000); chk("R7 erase verify", rv, 8'hF0 ^ 8'h5A);
    wr(17'h0, 8'h00);
  endtask

  task automatic t_latch();
    wrx(17'h00042, 17'h00099, 8'hA0, 8'hA0, 1'b1);
    rd(17'h00000); chk("R8 addr at fall", rv, 8'h42 ^ 8'h5A);
    wr(17'h0, 8'h00);
    wrx(17'h0, 17'h0, 8'h90, 8'h00, 1'b1);
    rd(17'h00001); chk("R8 data at rise", rv, 8'h01 ^ 8'h5A);
    wrx(17'h0, 17'h0, 8'h90, 8'h90, 1'b0);
    rd(17'h00001); chk("R8 ce high ignored", rv, 8'h01 ^ 8'h5A);
  endtask

  task automatic t_auto();
    int c0 = opCount;
    wr(17'h0, 8'h30); wr(17'h0, 8'h30);
    chk("R4 auto issued", opCount, c0 + 1);
    chk("R4 auto code", lastCode, 2'd2);
    rd(17'h00005);
    chk("R9 status busy", rv, 8'h00);
    chk("R9 status oe", ro, 8'h80);
    wr(17'h0, 8'h90);
    wr(17'h0, 8'h20); wr(17'h0, 8'h20);
    chk("R11 no op while busy", opCount, c0 + 1);
    rd(17'h00001); chk("R11 status still busy", rv, 8'h00);
    while (opBusy) @(negedge clk);
    repeat (2) @(negedge clk);
    rd(17'h00001);
    chk("R9 status done", rv, 8'h80);
    chk("R11 still status oe", ro, 8'h80);
    wr(17'h0, 8'h00);
    rd(17'h00003); chk("R9 leave status", rv, 8'h03 ^ 8'h5A);
  endtask

  task automatic t_vpp();
    int c0 = opCount;
    wr(17'h0, 8'h90);
    @(negedge clk); vppHigh = 1'b0;
    repeat (2) @(negedge clk);
    rd(17'h00001); chk("R13 forced array", rv, 8'h01 ^ 8'h5A);
    wr(17'h0, 8'h90);
    rd(17'h00000); chk("R13 cmd ignored", rv, 8'h5A);
    wr(17'h0, 8'h20); wr(17'h0, 8'h20);
    chk("R13 no op", opCount, c0);
    @(negedge clk); vppHigh = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired act=timeout exp=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ident();
    t_erase();
    t_rst();
    t_prog();
    t_latch();
    t_auto();
    t_vpp();
    summary();
  end
endmodule